// File: doc/BRIEF.md
# Vertical-Crosswise 8x8 Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns their 16-bit product in the same cycle. It has no clock and holds no state. The product is built bottom-up. Sixteen 2x2 cells form the leaf level, and each cell uses only AND gates and two half adders. Four cells make a 4x4 unit, and four 4x4 units make the 8x8 result.

At each join level, four half-width sub-products are merged: low-by-low, high-by-low, low-by-high and high-by-high. The two cross terms are added first. Their sum is then added, shifted by half the width, onto the concatenation of the high-by-high and low-by-low terms. The low half-width bits of the low-by-low term pass straight through.

A parameter chooses how every join-level addition is built. One option is a log-depth Kogge-Stone prefix adder. The other is a plain ripple-carry chain. Both options compute the same function.

Top module: `vcm_mult8`

## Requirements
- R1: With the prefix-adder option (ADDER = ADD_PREFIX, the default), `prod` equals the unsigned product `op_a * op_b` for every one of the 65536 operand pairs.
- R2: With the ripple option (ADDER = ADD_RIPPLE), `prod` equals the unsigned product `op_a * op_b` for every operand pair.
- R3: Both adder options give bit-identical 16-bit products for every operand pair.
- R4: When either operand is zero, `prod` is 16'h0000.
- R5: When one operand is 1, `prod` equals the other operand, zero-extended to 16 bits.
- R6: `prod` never exceeds 16'hFE01. With both operands at 8'hFF, the product is exactly 16'hFE01.
- R7: The product does not depend on operand order: swapping `op_a` and `op_b` gives the same `prod`.
- R8: `prod[0]` equals `op_a[0] & op_b[0]` for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | OPW (8) | Unsigned multiplicand |
| op_b | input | OPW (8) | Unsigned multiplier |
| prod | output | 2*OPW (16) | Unsigned product, combinational |

## Verification
The block is combinational, so a wrong sub-product or a broken carry appears at `prod` in the same evaluation as the operands that trigger it.

A fault in a leaf cell only shows for operands whose matching 2-bit slices exercise that cell's carry. A break in a prefix node only shows when a carry must travel across that node's span. Because these faults hide behind specific bit patterns, the bench applies all 65536 pairs to both adder options. Each product is compared with a value computed arithmetically in the bench, and the two options are compared with each other. A second prefix instance with swapped operands is compared against the first on every pair.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

   // Adder construction used at every join level of the multiplier tree.
   typedef enum logic {
      ADD_RIPPLE = 1'b0,
      ADD_PREFIX = 1'b1
   } vcm_add_e;

   // Leaf cell operand width; the recursion bottoms out here.
   localparam int CELL_W = 2;

endpackage

// File: rtl/vcm_cell2.sv
// 2x2 leaf cell: bit products are ANDs, carries come from two half adders.
module vcm_cell2 (
   input  logic [1:0] a,
   input  logic [1:0] b,
   output logic [3:0] p
);

   logic t_lo_hi;
   logic t_hi_lo;
   logic t_hi_hi;
   logic c_cross;

   assign t_hi_lo = a[1] & b[0];
   assign t_lo_hi = a[0] & b[1];
   assign t_hi_hi = a[1] & b[1];

   // column 0: the vertical product
   assign p[0] = a[0] & b[0];

   // column 1: the crosswise products, one half adder
   assign p[1]    = t_hi_lo ^ t_lo_hi;
   assign c_cross = t_hi_lo & t_lo_hi;

   // column 2/3: the upper vertical product plus the crosswise carry
   assign p[2] = t_hi_hi ^ c_cross;
   assign p[3] = t_hi_hi & c_cross;

endmodule

// File: rtl/vcm_add.sv
// W-bit adder with carry-in, sum truncated to W bits.
// KIND picks a ripple chain or a Kogge-Stone prefix tree for the carries.
module vcm_add #(
   parameter int                 W    = 4,
   parameter vcm_pkg::vcm_add_e  KIND = vcm_pkg::ADD_PREFIX
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] s
);

   // carries are needed into bits 1..W-1, so the carry network spans W-1 bits
   localparam int N   = W - 1;
   localparam int LVL = $clog2(N);

   if (W < 2) begin : g_bad_width
      $error("vcm_add: W must be at least 2");
   end

   logic [W-1:0] hsum;
   logic [W-1:0] cy;

   assign hsum  = x ^ y;
   assign cy[0] = cin;
   assign s     = hsum ^ cy;

   if (KIND == vcm_pkg::ADD_RIPPLE) begin : g_ripple
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign cy[i+1] = (x[i] & y[i]) | (hsum[i] & cy[i]);
      end
   end else begin : g_prefix
      // level-major flat storage of group generate / propagate
      logic [(LVL+1)*N-1:0] gv;
      logic [(LVL+1)*N-1:0] pv;

      assign gv[N-1:0] = x[N-1:0] & y[N-1:0];
      assign pv[N-1:0] = hsum[N-1:0];

      for (genvar lv = 0; lv < LVL; lv++) begin : g_level
         localparam int D = 1 << lv;
         for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= D) begin : g_merge
               assign gv[(lv+1)*N+i] = gv[lv*N+i] | (pv[lv*N+i] & gv[lv*N+i-D]);
               assign pv[(lv+1)*N+i] = pv[lv*N+i] & pv[lv*N+i-D];
            end else begin : g_pass
               assign gv[(lv+1)*N+i] = gv[lv*N+i];
               assign pv[(lv+1)*N+i] = pv[lv*N+i];
            end
         end
      end

      // after LVL levels every node spans down to bit 0; fold in carry-in
      for (genvar i = 0; i < N; i++) begin : g_carry
         assign cy[i+1] = gv[LVL*N+i] | (pv[LVL*N+i] & cin);
      end
   end

endmodule

// File: rtl/vcm_join.sv
// Merges four HxH sub-products into one 2Hx2H product:
//   ll + (hl << H) + (lh << H) + (hh << 2H)
module vcm_join #(
   parameter int                 H    = 2,
   parameter vcm_pkg::vcm_add_e  KIND = vcm_pkg::ADD_PREFIX
) (
   input  logic [2*H-1:0] ll,
   input  logic [2*H-1:0] hl,
   input  logic [2*H-1:0] lh,
   input  logic [2*H-1:0] hh,
   output logic [4*H-1:0] p
);

   localparam int MID_W = 2 * H + 1;
   localparam int UP_W  = 3 * H;

   if (H < vcm_pkg::CELL_W) begin : g_bad_half
      $error("vcm_join: H below leaf cell width");
   end

   logic [MID_W-1:0] cross_sum;
   logic [UP_W-1:0]  upper;

   // the two cross terms carry the same weight: add them first
   vcm_add #(.W(MID_W), .KIND(KIND)) u_cross (
      .x   ({1'b0, hl}),
      .y   ({1'b0, lh}),
      .cin (1'b0),
      .s   (cross_sum)
   );

   // low H bits of ll are final; the rest aligns with the cross sum
   vcm_add #(.W(UP_W), .KIND(KIND)) u_upper (
      .x   ({hh, ll[2*H-1:H]}),
      .y   ({{(H-1){1'b0}}, cross_sum}),
      .cin (1'b0),
      .s   (upper)
   );

   assign p = {upper, ll[H-1:0]};

endmodule

// File: rtl/vcm_mul4.sv
// 4x4 unit: four leaf cells and one join level.
module vcm_mul4 #(
   parameter vcm_pkg::vcm_add_e KIND = vcm_pkg::ADD_PREFIX
) (
   input  logic [3:0] a,
   input  logic [3:0] b,
   output logic [7:0] p
);

   localparam int CW = vcm_pkg::CELL_W;

   logic [2*CW-1:0] sub [4];

   // quadrant q: bit 0 picks the half of a, bit 1 the half of b
   for (genvar q = 0; q < 4; q++) begin : g_cell
      localparam int AI = q % 2;
      localparam int BI = q / 2;
      vcm_cell2 u_cell (
         .a (a[AI*CW +: CW]),
         .b (b[BI*CW +: CW]),
         .p (sub[q])
      );
   end

   vcm_join #(.H(CW), .KIND(KIND)) u_join (
      .ll (sub[0]),
      .hl (sub[1]),
      .lh (sub[2]),
      .hh (sub[3]),
      .p  (p)
   );

endmodule

// File: rtl/vcm_mult8.sv
// 8x8 unsigned multiplier: four 4x4 units merged by one join level.
module vcm_mult8 #(
   parameter int                 OPW   = 8,
   parameter vcm_pkg::vcm_add_e  ADDER = vcm_pkg::ADD_PREFIX
) (
   input  logic [OPW-1:0]   op_a,
   input  logic [OPW-1:0]   op_b,
   output logic [2*OPW-1:0] prod
);

   localparam int HW = OPW / 2;

   if (OPW != 8) begin : g_bad_opw
      $error("vcm_mult8: OPW must be 8 (two levels above the 2x2 cell)");
   end

   logic [2*HW-1:0] quad [4];

   for (genvar q = 0; q < 4; q++) begin : g_quad
      localparam int AI = q % 2;
      localparam int BI = q / 2;
      vcm_mul4 #(.KIND(ADDER)) u_mul4 (
         .a (op_a[AI*HW +: HW]),
         .b (op_b[BI*HW +: HW]),
         .p (quad[q])
      );
   end

   vcm_join #(.H(HW), .KIND(ADDER)) u_join (
      .ll (quad[0]),
      .hl (quad[1]),
      .lh (quad[2]),
      .hh (quad[3]),
      .p  (prod)
   );

endmodule

// File: rtl/vcm_mult8_chk.sv
// Property checker bound to every vcm_mult8 instance.
module vcm_mult8_chk #(
   parameter int OPW = 8
) (
   input logic [OPW-1:0]   op_a,
   input logic [OPW-1:0]   op_b,
   input logic [2*OPW-1:0] prod
);

   localparam int PW = 2 * OPW;
   localparam logic [PW-1:0] MAX_P = PW'((2**OPW - 1) * (2**OPW - 1));

   logic [PW-1:0] ref_p;
   assign ref_p = PW'(op_a) * PW'(op_b);

   always_comb begin
      if (!$isunknown({op_a, op_b, prod})) begin
         AST_PRODUCT_EXACT: assert (prod == ref_p);                                      // R1
         AST_ZERO_OPERAND:  assert (!((op_a == '0) || (op_b == '0)) || (prod == '0));    // R4
         AST_UNIT_A:        assert ((op_a != OPW'(1)) || (prod == PW'(op_b)));           // R5
         AST_UNIT_B:        assert ((op_b != OPW'(1)) || (prod == PW'(op_a)));           // R5
         AST_UPPER_BOUND:   assert (prod <= MAX_P);                                      // R6
         AST_LSB_AND:       assert (prod[0] == (op_a[0] & op_b[0]));                     // R8
      end
   end

endmodule

bind vcm_mult8 vcm_mult8_chk #(.OPW(OPW)) u_chk (
   .op_a (op_a),
   .op_b (op_b),
   .prod (prod)
);

// File: tb/vcm_mult8_tb.sv
module vcm_mult8_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a = 8'd0;
   logic [7:0] b = 8'd0;
   logic [15:0] p_pfx;
   logic [15:0] p_rca;
   logic [15:0] p_swp;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   vcm_mult8 #(.OPW(8), .ADDER(vcm_pkg::ADD_PREFIX)) u_dut (
      .op_a (a), .op_b (b), .prod (p_pfx)
   );

   vcm_mult8 #(.OPW(8), .ADDER(vcm_pkg::ADD_RIPPLE)) u_dut_rca (
      .op_a (a), .op_b (b), .prod (p_rca)
   );

   vcm_mult8 #(.OPW(8), .ADDER(vcm_pkg::ADD_PREFIX)) u_dut_swp (
      .op_a (b), .op_b (a), .prod (p_swp)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, a, b, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] exp;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // state right after reset: zero operands give a zero product
      check("R4 reset zero", p_pfx, 16'h0000);
      check("R4 reset zero rca", p_rca, 16'h0000);

      for (int ia = 0; ia < 256; ia++) begin
         for (int ib = 0; ib < 256; ib++) begin
            @(posedge clk);
            a = 8'(ia);
            b = 8'(ib);
            @(negedge clk);
            exp = 16'(ia * ib);
            check("R1 prefix product", p_pfx, exp);
            check("R2 ripple product", p_rca, exp);
            check("R3 variants agree", p_pfx, p_rca);
            check("R7 swapped order", p_swp, p_pfx);
            check("R8 lsb", {15'd0, p_pfx[0]}, {15'd0, a[0] & b[0]});
            if (ia == 0 || ib == 0)
               check("R4 zero operand", p_pfx, 16'h0000);
            if (ia == 1)
               check("R5 unit a", p_pfx, {8'd0, b});
            if (ib == 1)
               check("R5 unit b", p_rca, {8'd0, a});
            if (p_pfx > 16'hFE01)
               check("R6 bound", p_pfx, 16'hFE01);
         end
      end

      @(posedge clk);
      a = 8'hFF;
      b = 8'hFF;
      @(negedge clk);
      check("R6 max prefix", p_pfx, 16'hFE01);
      check("R6 max ripple", p_rca, 16'hFE01);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule